// File: doc/BRIEF.md
# Arithmetic Floating-Point Absolute Value and Negation Unit

This unit computes the absolute value or the negation of one floating-point operand per cycle. It treats both operations as arithmetic, not as sign-bit edits. A non-NaN operand behaves as if the unit computed `0 - x` (negation) or `0 ± x` (absolute value) with rounding toward minus infinity. Because of that, signed zeros come out as the arithmetic rules dictate. NaN operands are never sign-edited. A quiet NaN passes through bit for bit. A signalling NaN raises the Invalid Operation flag and is turned into a quiet NaN by one of two selectable quieting schemes.

Each cycle, the surrounding pipeline presents an operand on a 64-bit bus together with the operation, a format bit and a valid strobe. Double precision uses the whole bus. Single precision uses the low 32 bits. The result and the flag are registered and appear one cycle later, together with a delayed copy of the valid strobe.

Top module: `fpan_unit`

## Requirements
- R1: A quiet NaN operand (exponent all ones, trailing significand nonzero, top fraction bit 0 — bit 51 in double, bit 22 in single) gives a result equal to the operand bit for bit, sign included, for both operations, and `res_invalid` stays 0.
- R2: A signalling NaN operand (exponent all ones, top fraction bit 1) sets `res_invalid` to 1 in the output cycle, and `res_invalid` is only ever 1 while `res_valid` is 1.
- R3: With `quiet_mode` = 0, a signalling NaN gives the default quiet NaN with sign 0: 0x7FF7_FFFF_FFFF_FFFF in double and 0x7FBF_FFFF in single, whatever the input sign and payload.
- R4: With `quiet_mode` = 1, a signalling NaN keeps its sign and payload, with the top fraction bit cleared. If the fraction is then zero, the fraction bit just below the top (bit 50 in double, bit 22-1 = 21 in single) is set.
- R5: For a non-NaN, nonzero operand (normal, subnormal or infinity), the negate operation (`op_sel` = 1) returns the operand with only the sign bit inverted.
- R6: For a non-NaN operand, the absolute operation (`op_sel` = 0) returns the operand with the sign bit cleared and all other bits unchanged.
- R7: Signed zeros: negating +0 gives −0, negating −0 gives +0, and the absolute value of either zero is +0.
- R8: With `fmt_dbl` = 0, only bits 31:0 of `op_in` are used, bits 63:32 of `op_in` have no effect, and bits 63:32 of `res_out` are 0.
- R9: `res_valid` equals `op_valid` delayed by one clock, and the result for an operand accepted in one cycle is on `res_out` in the next cycle, including for back-to-back operands.
- R10: A synchronous active-high `rst` clears `res_valid` and `res_invalid` at the next clock edge, even if `op_valid` is high.
- R11: A non-NaN operand never sets `res_invalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operand strobe |
| op_sel | input | 1 | 0 = absolute value, 1 = negate |
| fmt_dbl | input | 1 | 1 = double precision, 0 = single precision |
| quiet_mode | input | 1 | Scheme for quieting a signalling NaN (0 = default NaN, 1 = keep payload) |
| op_in | input | 64 | Operand; single precision uses bits 31:0 |
| res_valid | output | 1 | Result strobe, one cycle after `op_valid` |
| res_out | output | 64 | Result |
| res_invalid | output | 1 | Invalid Operation flag for the result |

## Verification
The bench builds the unit with its default field widths: an 11-bit exponent with a 52-bit fraction for the double lane, and an 8-bit exponent with a 23-bit fraction for the single lane. With both lanes at their true IEEE sizes, the checks can use the exact double and single default-NaN constants. They also reach the quieting corner in which clearing the top fraction bit leaves an empty field, and they show that a stray high word on the bus does not reach a single-precision result. Double and single operands are mixed, back-to-back strobes are used, and a reset is applied in the middle of a run.

// File: rtl/fpan_pkg.sv
package fpan_pkg;

    // Default field widths of the two supported formats
    localparam int SGL_EXP  = 8;
    localparam int SGL_FRAC = 23;
    localparam int DBL_EXP  = 11;
    localparam int DBL_FRAC = 52;

    typedef enum logic {
        OP_ABS = 1'b0,
        OP_NEG = 1'b1
    } op_e;

    typedef enum logic [1:0] {
        CL_NUM,
        CL_ZERO,
        CL_QNAN,
        CL_SNAN
    } cls_e;

endpackage

// File: rtl/fpan_quieter.sv
// Turns a signalling NaN into a quiet NaN using one of two schemes.
module fpan_quieter #(
    parameter int EXP  = 11,
    parameter int FRAC = 52,
    localparam int W   = 1 + EXP + FRAC
) (
    input  logic            mode,
    input  logic            sign_in,
    input  logic [FRAC-1:0] frac_in,
    output logic [W-1:0]    nan_out
);

    logic [FRAC-1:0] frac_kept;
    logic [FRAC-1:0] frac_fix;

    always_comb begin
        frac_kept = frac_in;
        frac_kept[FRAC-1] = 1'b0;
        frac_fix = frac_kept;
        if (frac_kept == '0) begin
            frac_fix[FRAC-2] = 1'b1;
        end
        if (mode) begin
            nan_out = {sign_in, {EXP{1'b1}}, frac_fix};
        end else begin
            nan_out = {1'b0, {EXP{1'b1}}, 1'b0, {(FRAC-1){1'b1}}};
        end
    end

endmodule

// File: rtl/fpan_lane.sv
// One format lane: classify the operand and form the arithmetic result.
module fpan_lane
    import fpan_pkg::*;
#(
    parameter int EXP  = 11,
    parameter int FRAC = 52,
    localparam int W   = 1 + EXP + FRAC
) (
    input  logic         q_mode,
    input  op_e          op,
    input  logic [W-1:0] x,
    output logic [W-1:0] y,
    output logic         snan
);

    logic            x_sign;
    logic [EXP-1:0]  x_exp;
    logic [FRAC-1:0] x_frac;
    cls_e            cls;
    logic [W-1:0]    quiet_nan;

    assign x_sign = x[W-1];
    assign x_exp  = x[W-2:FRAC];
    assign x_frac = x[FRAC-1:0];

    always_comb begin
        if (&x_exp && |x_frac) begin
            cls = x_frac[FRAC-1] ? CL_SNAN : CL_QNAN;
        end else if (x_exp == '0 && x_frac == '0) begin
            cls = CL_ZERO;
        end else begin
            cls = CL_NUM;
        end
    end

    fpan_quieter #(
        .EXP (EXP),
        .FRAC(FRAC)
    ) i_quieter (
        .mode   (q_mode),
        .sign_in(x_sign),
        .frac_in(x_frac),
        .nan_out(quiet_nan)
    );

    always_comb begin
        snan = 1'b0;
        unique case (cls)
            CL_QNAN: y = x;
            CL_SNAN: begin
                y    = quiet_nan;
                snan = 1'b1;
            end
            // 0 - (+0) = -0 and 0 - (-0) = +0 when rounding toward -inf
            CL_ZERO: y = {(op == OP_NEG) ? ~x_sign : 1'b0, x_exp, x_frac};
            default: y = {(op == OP_NEG) ? ~x_sign : 1'b0, x_exp, x_frac};
        endcase
    end

endmodule

// File: rtl/fpan_unit.sv
module fpan_unit
    import fpan_pkg::*;
#(
    parameter int EXP_D  = DBL_EXP,
    parameter int FRAC_D = DBL_FRAC,
    parameter int EXP_S  = SGL_EXP,
    parameter int FRAC_S = SGL_FRAC,
    localparam int W_D   = 1 + EXP_D + FRAC_D,
    localparam int W_S   = 1 + EXP_S + FRAC_S
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           op_valid,
    input  logic           op_sel,
    input  logic           fmt_dbl,
    input  logic           quiet_mode,
    input  logic [W_D-1:0] op_in,
    output logic           res_valid,
    output logic [W_D-1:0] res_out,
    output logic           res_invalid
);

    typedef struct packed {
        logic           vld;
        logic           inv;
        logic [W_D-1:0] res;
    } state_t;

    state_t         st_d;
    state_t         st_q;
    op_e            op;
    logic [W_D-1:0] res_dbl;
    logic [W_S-1:0] res_sgl;
    logic           snan_dbl;
    logic           snan_sgl;

    assign op = op_e'(op_sel);

    fpan_lane #(
        .EXP (EXP_D),
        .FRAC(FRAC_D)
    ) i_lane_dbl (
        .q_mode(quiet_mode),
        .op    (op),
        .x     (op_in),
        .y     (res_dbl),
        .snan  (snan_dbl)
    );

    fpan_lane #(
        .EXP (EXP_S),
        .FRAC(FRAC_S)
    ) i_lane_sgl (
        .q_mode(quiet_mode),
        .op    (op),
        .x     (op_in[W_S-1:0]),
        .y     (res_sgl),
        .snan  (snan_sgl)
    );

    always_comb begin
        st_d.vld = op_valid;
        if (fmt_dbl) begin
            st_d.res = res_dbl;
            st_d.inv = op_valid & snan_dbl;
        end else begin
            st_d.res = {{(W_D - W_S){1'b0}}, res_sgl};
            st_d.inv = op_valid & snan_sgl;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid   = st_q.vld;
    assign res_invalid = st_q.inv;
    assign res_out     = st_q.res;

endmodule

// File: rtl/fpan_unit_chk.sv
module fpan_unit_chk
    import fpan_pkg::*;
#(
    parameter int EXP_D  = DBL_EXP,
    parameter int FRAC_D = DBL_FRAC,
    localparam int W_D   = 1 + EXP_D + FRAC_D
) (
    input logic           clk,
    input logic           rst,
    input logic           op_valid,
    input logic           op_sel,
    input logic           fmt_dbl,
    input logic           quiet_mode,
    input logic [W_D-1:0] op_in,
    input logic           res_valid,
    input logic [W_D-1:0] res_out,
    input logic           res_invalid
);

    logic d_expones;
    logic d_qnan;
    logic d_snan;
    logic [W_D-1:0] dflt_nan;

    assign d_expones = fmt_dbl && (&op_in[W_D-2:FRAC_D]);
    assign d_qnan    = d_expones && !op_in[FRAC_D-1] && (|op_in[FRAC_D-2:0]);
    assign d_snan    = d_expones && op_in[FRAC_D-1];
    assign dflt_nan  = {1'b0, {EXP_D{1'b1}}, 1'b0, {(FRAC_D-1){1'b1}}};

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> res_valid); // R9
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> !res_valid); // R9
    AST_FLAG_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
        res_invalid |-> res_valid); // R2
    AST_QNAN_PASS: assert property (@(posedge clk) disable iff (rst)
        (op_valid && d_qnan) |=> (res_out == $past(op_in) && !res_invalid)); // R1
    AST_SNAN_FLAG: assert property (@(posedge clk) disable iff (rst)
        (op_valid && d_snan) |=> res_invalid); // R2
    AST_DEFAULT_NAN: assert property (@(posedge clk) disable iff (rst)
        (op_valid && d_snan && !quiet_mode) |=> (res_out == dflt_nan)); // R3
    AST_NUM_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
        (op_valid && fmt_dbl && !d_expones) |=> !res_invalid); // R11
    AST_SGL_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !fmt_dbl) |=> (res_out[W_D-1:32] == '0)); // R8
    AST_NEG_SIGN: assert property (@(posedge clk) disable iff (rst)
        (op_valid && fmt_dbl && !d_expones && op_sel)
        |=> (res_out == {~$past(op_in[W_D-1]), $past(op_in[W_D-2:0])})); // R5
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!res_valid && !res_invalid)); // R10

endmodule

bind fpan_unit fpan_unit_chk i_fpan_unit_chk (
    .clk        (clk),
    .rst        (rst),
    .op_valid   (op_valid),
    .op_sel     (op_sel),
    .fmt_dbl    (fmt_dbl),
    .quiet_mode (quiet_mode),
    .op_in      (op_in),
    .res_valid  (res_valid),
    .res_out    (res_out),
    .res_invalid(res_invalid)
);

// File: tb/test_fpan_unit.sv
`timescale 1ns/1ps
module test_fpan_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic        op_sel = 1'b0;
    logic        fmt_dbl = 1'b0;
    logic        quiet_mode = 1'b0;
    logic [63:0] op_in = '0;
    logic        res_valid;
    logic [63:0] res_out;
    logic        res_invalid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    fpan_unit i_fpan_unit (
        .clk        (clk),
        .rst        (rst),
        .op_valid   (op_valid),
        .op_sel     (op_sel),
        .fmt_dbl    (fmt_dbl),
        .quiet_mode (quiet_mode),
        .op_in      (op_in),
        .res_valid  (res_valid),
        .res_out    (res_out),
        .res_invalid(res_invalid)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic op, input logic dbl, input logic qm, input logic [63:0] x);
        op_valid   = 1'b1;
        op_sel     = op;
        fmt_dbl    = dbl;
        quiet_mode = qm;
        op_in      = x;
    endtask

    // One operand, result checked one cycle later
    task automatic run_op(input string req, input logic op, input logic dbl, input logic qm,
                          input logic [63:0] x, input logic [63:0] exp_res, input logic exp_inv);
        @(negedge clk);
        drive(op, dbl, qm, x);
        @(negedge clk);
        op_valid = 1'b0;
        check(req, {63'd0, res_valid}, 64'd1);
        check(req, res_out, exp_res);
        check(req, {63'd0, res_invalid}, {63'd0, exp_inv});
    endtask

    task automatic t_reset_state();
        check("R10 reset valid", {63'd0, res_valid}, 64'd0);
        check("R10 reset flag", {63'd0, res_invalid}, 64'd0);
    endtask

    task automatic t_quiet_nan();
        run_op("R1 dbl qnan neg", 1'b1, 1'b1, 1'b0, 64'hFFF0_0000_0000_0001, 64'hFFF0_0000_0000_0001, 1'b0);
        run_op("R1 dbl qnan abs", 1'b0, 1'b1, 1'b1, 64'hFFF7_0000_0000_0000, 64'hFFF7_0000_0000_0000, 1'b0);
        run_op("R1 sgl qnan neg", 1'b1, 1'b0, 1'b0, 64'h0000_0000_7F80_0005, 64'h0000_0000_7F80_0005, 1'b0);
    endtask

    task automatic t_snan_mode0();
        run_op("R3 R2 dbl snan abs", 1'b0, 1'b1, 1'b0, 64'hFFF8_0000_0000_1234, 64'h7FF7_FFFF_FFFF_FFFF, 1'b1);
        run_op("R3 R2 sgl snan neg", 1'b1, 1'b0, 1'b0, 64'h0000_0000_FFC0_0001, 64'h0000_0000_7FBF_FFFF, 1'b1);
    endtask

    task automatic t_snan_mode1();
        run_op("R4 dbl keep payload", 1'b1, 1'b1, 1'b1, 64'hFFF8_0000_0000_1234, 64'hFFF0_0000_0000_1234, 1'b1);
        run_op("R4 dbl empty fix", 1'b0, 1'b1, 1'b1, 64'h7FF8_0000_0000_0000, 64'h7FF4_0000_0000_0000, 1'b1);
        run_op("R4 sgl empty fix", 1'b0, 1'b0, 1'b1, 64'h0000_0000_FFC0_0000, 64'h0000_0000_FFA0_0000, 1'b1);
        run_op("R4 sgl keep payload", 1'b1, 1'b0, 1'b1, 64'h0000_0000_7FC0_0010, 64'h0000_0000_7F80_0010, 1'b1);
    endtask

    task automatic t_negate();
        run_op("R5 R11 dbl one", 1'b1, 1'b1, 1'b0, 64'h3FF0_0000_0000_0000, 64'hBFF0_0000_0000_0000, 1'b0);
        run_op("R5 R11 dbl -inf", 1'b1, 1'b1, 1'b1, 64'hFFF0_0000_0000_0000, 64'h7FF0_0000_0000_0000, 1'b0);
        run_op("R5 sgl value", 1'b1, 1'b0, 1'b0, 64'h0000_0000_C049_0FDB, 64'h0000_0000_4049_0FDB, 1'b0);
        run_op("R5 sgl subnormal", 1'b1, 1'b0, 1'b0, 64'h0000_0000_0000_0001, 64'h0000_0000_8000_0001, 1'b0);
    endtask

    task automatic t_absolute();
        run_op("R6 dbl negative", 1'b0, 1'b1, 1'b0, 64'hC000_0000_0000_0000, 64'h4000_0000_0000_0000, 1'b0);
        run_op("R6 sgl positive", 1'b0, 1'b0, 1'b0, 64'h0000_0000_3F80_0000, 64'h0000_0000_3F80_0000, 1'b0);
        run_op("R6 R11 sgl -inf", 1'b0, 1'b0, 1'b0, 64'h0000_0000_FF80_0000, 64'h0000_0000_7F80_0000, 1'b0);
    endtask

    task automatic t_zeros();
        run_op("R7 neg +0 dbl", 1'b1, 1'b1, 1'b0, 64'h0000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0);
        run_op("R7 neg -0 dbl", 1'b1, 1'b1, 1'b0, 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0000, 1'b0);
        run_op("R7 abs -0 sgl", 1'b0, 1'b0, 1'b0, 64'h0000_0000_8000_0000, 64'h0000_0000_0000_0000, 1'b0);
        run_op("R7 abs +0 sgl", 1'b0, 1'b0, 1'b0, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000, 1'b0);
    endtask

    task automatic t_single_upper();
        run_op("R8 upper junk", 1'b1, 1'b0, 1'b0, 64'hDEAD_BEEF_3F80_0000, 64'h0000_0000_BF80_0000, 1'b0);
        run_op("R8 upper junk nan", 1'b0, 1'b0, 1'b0, 64'hFFFF_FFFF_7F80_0005, 64'h0000_0000_7F80_0005, 1'b0);
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        drive(1'b1, 1'b1, 1'b0, 64'h4000_0000_0000_0000);
        @(negedge clk);
        drive(1'b0, 1'b0, 1'b0, 64'h0000_0000_BF80_0000);
        check("R9 first valid", {63'd0, res_valid}, 64'd1);
        check("R9 first result", res_out, 64'hC000_0000_0000_0000);
        @(negedge clk);
        op_valid = 1'b0;
        check("R9 second valid", {63'd0, res_valid}, 64'd1);
        check("R9 second result", res_out, 64'h0000_0000_3F80_0000);
        @(negedge clk);
        check("R9 valid drops", {63'd0, res_valid}, 64'd0);
    endtask

    task automatic t_mid_reset();
        run_op("R2 before reset", 1'b0, 1'b1, 1'b0, 64'h7FF8_0000_0000_0001, 64'h7FF7_FFFF_FFFF_FFFF, 1'b1);
        rst = 1'b1;
        drive(1'b0, 1'b1, 1'b0, 64'h7FF8_0000_0000_0001);
        @(negedge clk);
        check("R10 valid cleared", {63'd0, res_valid}, 64'd0);
        check("R10 flag cleared", {63'd0, res_invalid}, 64'd0);
        rst = 1'b0;
        op_valid = 1'b0;
        @(negedge clk);
        check("R10 idle after reset", {63'd0, res_valid}, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        rst = 1'b0;
        t_quiet_nan();
        t_snan_mode0();
        t_snan_mode1();
        t_negate();
        t_absolute();
        t_zeros();
        t_single_upper();
        t_back_to_back();
        t_mid_reset();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule